// File: doc/BRIEF.md
# Windowed Watchdog with Reset Generator

This block supervises a microcontroller that must prove it is alive by pulling an active-low trigger line low at the right moments. Once released from reset, the supervisor grants a long first interval in which the initial trigger may arrive at any point. Every accepted trigger then opens a fixed cycle: a closed interval, in which a trigger is a fault, followed by an open interval, in which a trigger is the expected response and starts the next cycle. A missing trigger or one that arrives too early drives the active-low reset output for a fixed length. After that the whole sequence begins again with the long first interval.

All durations are counted in strobes of a `tick` input, so one prescaler set by the surrounding chip scales the long first interval, both window lengths and the reset pulse. A trigger is only accepted if the line stays low for a minimum number of clock cycles, which filters glitches. The `enable` input comes from the mode controller. While it is low the watchdog holds its timers cleared and keeps the reset output released.

Top module: `win_watchdog`

## Requirements
- R1: A trigger is accepted only when `trig_n`, after a two-flop synchronizer, stays low for at least MIN_LOW_CLKS consecutive clock samples. A shorter low pulse has no effect, and a line held low for any length counts as one trigger.
- R2: After `rst_n` is released, after each reset pulse and after `enable` rises, a first interval of INIT_TICKS ticks begins. A trigger accepted in it starts a closed window. If none arrives, `rst_out_n` goes low at the end of the interval.
- R3: A trigger accepted during the closed window (CLOSED_TICKS ticks) drives `rst_out_n` low at once.
- R4: A trigger accepted during the open window (OPEN_TICKS ticks, which follows the closed window) starts a new closed window and does not cause a reset.
- R5: If the open window ends with no accepted trigger, `rst_out_n` goes low.
- R6: A reset pulse holds `rst_out_n` low for PULSE_TICKS ticks and ignores triggers. It is followed by a new first interval.
- R7: While `enable` is low, `rst_out_n` stays high, all timers are held cleared and triggers are ignored.
- R8: Timers advance only on clock cycles where `tick` is high, so every duration is that number of tick strobes.
- R9: With `tick` held high, an accepted trigger acts on the clock edge MIN_LOW_CLKS+2 edges after the edge that first samples it low. A window of N ticks that starts at edge E ends at edge E+N, and a trigger acting on that same edge is treated as being inside the window.
- R10: While `rst_n` is low, `rst_out_n` is high and the watchdog is in its first interval with its timers cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block |
| enable | input | 1 | Watchdog enable from the mode controller |
| tick | input | 1 | Time-base strobe; all durations count these |
| trig_n | input | 1 | Active-low trigger from the microcontroller |
| rst_out_n | output | 1 | Active-low reset to the microcontroller |

## Verification
The trigger width is swept from one cycle up to well past the minimum. This separates rejected glitches from accepted triggers and shows that a long low counts only once. A second trigger is then swept through every cycle offset after the first, across the closed window, the open window and past its end. The reset edge shows whether the block saw a fault, a re-arm or a timeout, and each boundary offset is pinned to its cycle. Disabling during the first interval and in mid-cycle, and running with a tick at half rate, show that enable clears the schedule and that only tick strobes count.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;

    typedef enum logic [1:0] {
        PH_INIT   = 2'd0,
        PH_CLOSED = 2'd1,
        PH_OPEN   = 2'd2,
        PH_RESET  = 2'd3
    } wd_phase_e;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/win_wdog_trig_filter.sv
module win_wdog_trig_filter #(
    parameter int unsigned MIN_LOW_CLKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic trig_n,
    output logic accept
);
    localparam int unsigned CW = (MIN_LOW_CLKS < 2) ? 1 : $clog2(MIN_LOW_CLKS + 1);
    localparam logic [CW-1:0] LOW_MAX  = CW'(MIN_LOW_CLKS);
    localparam logic [CW-1:0] LOW_LAST = CW'(MIN_LOW_CLKS - 1);

    typedef struct packed {
        logic          sync1;
        logic          sync2;
        logic [CW-1:0] low_cnt;
        logic          acc;
    } filt_t;

    filt_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.sync1 = trig_n;
        st_d.sync2 = st_q.sync1;
        st_d.acc   = 1'b0;
        if (!enable || st_q.sync2) begin
            st_d.low_cnt = '0;
        end else if (st_q.low_cnt != LOW_MAX) begin
            st_d.acc     = (st_q.low_cnt == LOW_LAST);
            st_d.low_cnt = st_q.low_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sync1: 1'b1, sync2: 1'b1, low_cnt: '0, acc: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign accept = st_q.acc;

endmodule

// File: rtl/win_wdog_phase_timer.sv
module win_wdog_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t st_d, st_q;

    assign expire = tick && (st_q.cnt == limit);

    always_comb begin
        st_d = st_q;
        if (clear || expire) begin
            st_d.cnt = '0;
        end else if (tick) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/win_watchdog.sv
module win_watchdog #(
    parameter int unsigned INIT_TICKS   = 1550,
    parameter int unsigned CLOSED_TICKS = 206,
    parameter int unsigned OPEN_TICKS   = 210,
    parameter int unsigned PULSE_TICKS  = 40,
    parameter int unsigned MIN_LOW_CLKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic tick,
    input  logic trig_n,
    output logic rst_out_n
);
    import win_wdog_pkg::*;

    localparam int unsigned MAX_TICKS = max4(INIT_TICKS, CLOSED_TICKS, OPEN_TICKS, PULSE_TICKS);
    localparam int unsigned CNT_W     = (MAX_TICKS < 3) ? 1 : $clog2(MAX_TICKS);
    localparam logic [CNT_W-1:0] LIM_INIT   = CNT_W'(INIT_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_CLOSED = CNT_W'(CLOSED_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_OPEN   = CNT_W'(OPEN_TICKS - 1);
    localparam logic [CNT_W-1:0] LIM_PULSE  = CNT_W'(PULSE_TICKS - 1);

    typedef struct packed {
        wd_phase_e phase;
        logic      out_n;
    } wd_t;

    wd_t              st_d, st_q;
    logic             trig_ok;
    logic             expire;
    logic             tmr_clear;
    logic [CNT_W-1:0] limit;
    wd_phase_e        phase_q;

    assign phase_q = st_q.phase;

    win_wdog_trig_filter #(
        .MIN_LOW_CLKS(MIN_LOW_CLKS)
    ) u_filter (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(enable),
        .trig_n(trig_n),
        .accept(trig_ok)
    );

    always_comb begin
        unique case (st_q.phase)
            PH_INIT:   limit = LIM_INIT;
            PH_CLOSED: limit = LIM_CLOSED;
            PH_OPEN:   limit = LIM_OPEN;
            default:   limit = LIM_PULSE;
        endcase
    end

    win_wdog_phase_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .tick  (tick),
        .limit (limit),
        .expire(expire)
    );

    always_comb begin
        st_d = st_q;
        if (!enable) begin
            st_d.phase = PH_INIT;
        end else begin
            unique case (st_q.phase)
                PH_INIT: begin
                    if (trig_ok)     st_d.phase = PH_CLOSED;
                    else if (expire) st_d.phase = PH_RESET;
                end
                PH_CLOSED: begin
                    if (trig_ok)     st_d.phase = PH_RESET;
                    else if (expire) st_d.phase = PH_OPEN;
                end
                PH_OPEN: begin
                    if (trig_ok)     st_d.phase = PH_CLOSED;
                    else if (expire) st_d.phase = PH_RESET;
                end
                default: begin
                    if (expire)      st_d.phase = PH_INIT;
                end
            endcase
        end
        st_d.out_n = (st_d.phase != PH_RESET);
        tmr_clear  = !enable || (st_d.phase != st_q.phase);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_INIT, out_n: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rst_out_n = st_q.out_n;

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
    parameter int unsigned PULSE_TICKS = 40
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   enable,
    input logic                   tick,
    input logic                   trig_ok,
    input win_wdog_pkg::wd_phase_e phase,
    input logic                   rst_out_n
);
    import win_wdog_pkg::*;

    int unsigned pulse_ticks;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_ticks <= 0;
        end else if (phase == PH_RESET) begin
            if (tick) pulse_ticks <= pulse_ticks + 1;
        end else begin
            pulse_ticks <= 0;
        end
    end

    // R1: one acceptance per low phase, never two in a row
    p_single_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_ok |=> !trig_ok);

    // R2: a trigger in the first interval opens a closed window
    p_init_trigger_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_INIT && trig_ok) |=> (phase == PH_CLOSED));

    // R3: early trigger is a fault
    p_closed_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_CLOSED && trig_ok) |=> (phase == PH_RESET && !rst_out_n));

    // R4: trigger in the open window re-arms
    p_open_rearm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_OPEN && trig_ok) |=> (phase == PH_CLOSED && rst_out_n));

    // R6: pulse never exceeds its tick count and leads back to the first interval
    p_pulse_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_RESET) |-> (pulse_ticks < PULSE_TICKS));

    p_pulse_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && phase == PH_RESET) |=> (phase == PH_RESET || phase == PH_INIT));

    // R7: disabled means released and parked
    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (rst_out_n && phase == PH_INIT));

    // R8: nothing moves without a tick or a trigger
    p_tick_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !tick && !trig_ok) |=> $stable(phase));

endmodule

bind win_watchdog win_watchdog_chk #(
    .PULSE_TICKS(PULSE_TICKS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tick     (tick),
    .trig_ok  (trig_ok),
    .phase    (phase_q),
    .rst_out_n(rst_out_n)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/100ps
module win_watchdog_bench;

    localparam int I = 20;
    localparam int C = 8;
    localparam int O = 6;
    localparam int P = 3;
    localparam int M = 3;
    localparam int LAT = M + 3;   // negedge drive at cycle n -> acts at edge n+LAT

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b1;
    logic trig_n = 1'b1;
    logic tick_div = 1'b0;
    logic tick;
    logic rst_out_n;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int nfall = 0;
    int fall1 = -1;
    int fall2 = -1;
    int rise1 = -1;
    bit rose = 0;
    logic prev_out = 1'b1;
    bit finished = 0;

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    assign tick = tick_div ? cyc[0] : 1'b1;

    win_watchdog #(
        .INIT_TICKS  (I),
        .CLOSED_TICKS(C),
        .OPEN_TICKS  (O),
        .PULSE_TICKS (P),
        .MIN_LOW_CLKS(M)
    ) u_win_watchdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .tick     (tick),
        .trig_n   (trig_n),
        .rst_out_n(rst_out_n)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (!rst_out_n && prev_out) begin
                nfall = nfall + 1;
                if (nfall == 1) fall1 = cyc;
                else if (nfall == 2) fall2 = cyc;
            end
            if (rst_out_n && !prev_out && nfall == 1 && !rose) begin
                rise1 = cyc;
                rose  = 1;
            end
        end
        prev_out = rst_out_n;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step(input int k);
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic wait_until(input int target);
        while (cyc < target) begin
            @(negedge clk);
            #1;
        end
    endtask

    task automatic arm();
        nfall = 0;
        fall1 = -1;
        fall2 = -1;
        rise1 = -1;
        rose  = 0;
    endtask

    task automatic restart(output int rel);
        rst_n = 1'b0;
        trig_n = 1'b1;
        step(3);
        chk("R10 output released in reset", int'(rst_out_n), 1);
        rst_n = 1'b1;
        arm();
        rel = cyc;
    endtask

    task automatic pulse(input int w, output int s);
        trig_n = 1'b0;
        s = cyc;
        step(w);
        trig_n = 1'b1;
    endtask

    // edge index of the nth tick edge after edge 'from' with half-rate tick
    function automatic int div_edge(input int from, input int n);
        int cnt = 0;
        int k = from;
        while (cnt < n) begin
            k = k + 1;
            if (((k - 1) & 1) == 1) cnt = cnt + 1;
        end
        return k;
    endfunction

    initial begin
        #(200000 * 4);
        if (!finished) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int rel, sa, sb, m, exp1;
        step(2);

        // R1/R2/R9: pulse width sweep inside the first interval
        for (int w = 1; w <= M + 6; w++) begin
            restart(rel);
            step(2);
            pulse(w, sa);
            wait_until(rel + I + C + O + LAT + 10);
            exp1 = (w < M) ? rel + I : sa + LAT + C + O;
            chk($sformatf("R1 width %0d first reset edge", w), fall1, exp1);
        end

        // R3/R4/R5/R6/R9: second trigger swept across the windows
        for (int d = M + 1; d <= C + O + 3; d++) begin
            restart(rel);
            step(2);
            pulse(M, sa);
            wait_until(sa + d);
            pulse(M, sb);
            wait_until(sa + LAT + 2 * (C + O) + P + I + 12);
            if (d <= C)
                exp1 = sa + LAT + d;
            else if (d <= C + O)
                exp1 = sa + LAT + d + C + O;
            else
                exp1 = sa + LAT + C + O;
            if (d <= C)
                chk($sformatf("R3 offset %0d fault edge", d), fall1, exp1);
            else if (d <= C + O)
                chk($sformatf("R4 offset %0d rearm then timeout edge", d), fall1, exp1);
            else
                chk($sformatf("R5 offset %0d timeout edge", d), fall1, exp1);
            chk($sformatf("R6 offset %0d pulse end", d), rise1, exp1 + P);
            chk($sformatf("R6 offset %0d restart first interval", d), fall2, exp1 + P + I);
        end

        // R7: disabled during first interval, trigger while disabled ignored
        restart(rel);
        step(2);
        enable = 1'b0;
        step(2);
        pulse(M, sa);
        step(I + 10);
        chk("R7 no reset while disabled", nfall, 0);
        chk("R7 output high while disabled", int'(rst_out_n), 1);
        enable = 1'b1;
        m = cyc;
        wait_until(m + I + 5);
        chk("R7 fresh first interval after enable", fall1, m + I);

        // R7: disabled in the middle of a closed window
        restart(rel);
        step(2);
        pulse(M, sa);
        wait_until(sa + LAT + 2);
        enable = 1'b0;
        step(C + O + 10);
        chk("R7 no reset when disabled mid cycle", nfall, 0);
        enable = 1'b1;
        m = cyc;
        wait_until(m + I + 5);
        chk("R7 schedule cleared by disable", fall1, m + I);

        // R8: half-rate tick
        tick_div = 1'b1;
        restart(rel);
        wait_until(div_edge(rel, I) + 2 * P + 6);
        exp1 = div_edge(rel, I);
        chk("R8 first interval in ticks", fall1, exp1);
        chk("R8 pulse length in ticks", rise1, div_edge(exp1, P));
        tick_div = 1'b0;

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule